// File: doc/BRIEF.md
# Page-Mode Byte Memory Bus Controller

This block is a synchronous model of an asynchronous, SRAM-style byte memory front end. A fast system clock samples the active-low chip enable, write enable and output enable, the address, the write data and an active-low low-voltage lockout. All of these inputs pass through a two-flop synchroniser. An internal behavioural byte array is sequenced through four phases: address latch, access, page access and precharge. All timing is counted in clock cycles.

When chip enable falls, an access opens. While chip enable stays low, a change of the row bits (address bits above the low three) starts a slow random access. A change of only the low three bits selects another byte of the same 8-byte row, using the short page timing. The controller decides when the read data may be driven and when a write commits. It also presents the latched address to an external sector-protect lookup and drops any write that the lookup reports as protected.

The bus is split into `dq_i`, `dq_o` and the enable `dq_oe_o`, so the pad can be placed outside the block. The behavioural array holds 2^`STORE_AW` bytes. Set `STORE_AW` equal to `AW` to get the full 128K x 8 space.

Top module: `pgmem_ctrl`

## Requirements
- R1: After reset, and while chip enable is high, `dq_oe_o` is 0.
- R2: A chip-enable-started read of address A drives `dq_o` = mem[A] with `dq_oe_o`=1 from the (T_CE+3)-th rising clock edge after the input change, counting the first edge that follows it. It is not driven at the (T_CE+1)-th edge.
- R3: With chip enable held low, a change of `addr_i[2:0]` alone releases the bus within 3 edges. The new byte is driven from the (T_PAGE+3)-th edge.
- R4: With chip enable held low, a change of `addr_i[16:3]` starts a random access. The bus stays released at edge T_PAGE+4 and drives the new byte from edge T_RAND+3.
- R5: Raising chip enable starts a precharge of T_PRE cycles. A chip-enable fall during the precharge is deferred, and its access time counts only after the precharge ends.
- R6: The bus is driven only while output enable is low. Raising output enable tri-states it within 3 edges, and lowering it again drives the same data.
- R7: The bus is never driven while write enable is low. A write-enable-controlled write begins as a read and releases the bus within 3 edges of the write-enable fall.
- R8: A write commits `dq_i` to the latched address on the first of the write-enable rise or the chip-enable rise. Each write-enable pulse writes one byte, so several pulses with column changes write several bytes of one row.
- R9: A write whose ending edge arrives before the access time has elapsed leaves the array unchanged.
- R10: While `lockout_ni` is 0, the bus is not driven and no write reaches the array.
- R11: `wp_addr_o` shows the latched address. A write is dropped when `wp_protected_i` is 1 at the commit edge.
- R12: The array is indexed by `addr[STORE_AW-1:0]`, so addresses that agree in those bits share one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| lockout_ni | input | 1 | Low-voltage lockout, 0 blocks all access |
| addr_i | input | AW | Byte address; low 3 bits pick the column |
| dq_i | input | DW | Write data from the bus |
| dq_o | output | DW | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable |
| wp_addr_o | output | AW | Address under test by the sector-protect lookup |
| wp_protected_i | input | 1 | 1 when `wp_addr_o` lies in a protected sector |

## Verification
The assertions assume that the synchronised controls follow a legal bus protocol. The address is steady while write enable is low. Data is set before the write pulse ends. Chip enable is held long enough for an access to complete before a write that should land. The stimulus changes inputs only on falling clock edges and waits out the full access or precharge count before each write. The one deliberately short chip-enable pulse is used to show that an early write is dropped.

// File: rtl/pgmem_pkg.sv
package pgmem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_RDY  = 2'd2,
    ST_PRE  = 2'd3
  } pm_state_e;
endpackage

// File: rtl/pgmem_sync.sv
module pgmem_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pgmem_timer.sv
module pgmem_timer #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pgmem_array.sv
module pgmem_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pgmem_ctrl.sv
module pgmem_ctrl
  import pgmem_pkg::*;
#(
  parameter int AW          = 17,
  parameter int DW          = 8,
  parameter int COL_W       = 3,
  parameter int STORE_AW    = 10,
  parameter int SYNC_STAGES = 2,
  parameter int T_CE        = 6,
  parameter int T_RAND      = 35,
  parameter int T_PAGE      = 3,
  parameter int T_PRE       = 29
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic          lockout_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic [AW-1:0] wp_addr_o,
  input  logic          wp_protected_i
);
  localparam int T_MAX1 = (T_CE > T_RAND) ? T_CE : T_RAND;
  localparam int T_MAX2 = (T_PAGE > T_PRE) ? T_PAGE : T_PRE;
  localparam int T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
  localparam int CNT_W  = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] LD_CE   = CNT_W'(T_CE - 1);
  localparam logic [CNT_W-1:0] LD_RAND = CNT_W'(T_RAND - 1);
  localparam logic [CNT_W-1:0] LD_PAGE = CNT_W'(T_PAGE - 1);
  localparam logic [CNT_W-1:0] LD_PRE  = CNT_W'(T_PRE - 1);
  localparam int SW = 4 + AW + DW;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 3'b111, {AW{1'b0}}, {DW{1'b0}}};

  // synchronised inputs
  logic [SW-1:0] sync_q;
  logic          lvl_s, oe_s, we_s, ce_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] dq_s;

  pgmem_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({lockout_ni, oe_ni, we_ni, ce_ni, addr_i, dq_i}),
    .q_o   (sync_q)
  );

  assign {lvl_s, oe_s, we_s, ce_s, addr_s, dq_s} = sync_q;

  pm_state_e     state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          we_q;
  logic          lat_en;
  logic          tmr_ld, tmr_done;
  logic [CNT_W-1:0] tmr_val, tmr_cnt;
  logic          row_chg, col_chg, we_rise, wr_end, mem_we;
  logic [DW-1:0] rd_data;

  pgmem_timer #(.W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_ld),
    .load_val_i(tmr_val),
    .cnt_o     (tmr_cnt),
    .done_o    (tmr_done)
  );

  assign row_chg = (addr_s[AW-1:COL_W] != addr_q[AW-1:COL_W]);
  assign col_chg = (addr_s[COL_W-1:0] != addr_q[COL_W-1:0]);
  assign we_rise = we_s & ~we_q;

  always_comb begin
    state_d = state_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    lat_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!ce_s) begin
          state_d = ST_ACC;
          tmr_ld  = 1'b1;
          tmr_val = LD_CE;
          lat_en  = 1'b1;
        end
      end
      ST_ACC: begin
        if (ce_s) begin
          state_d = ST_PRE;
          tmr_ld  = 1'b1;
          tmr_val = LD_PRE;
        end else if (row_chg) begin
          tmr_ld  = 1'b1;
          tmr_val = LD_RAND;
          lat_en  = 1'b1;
        end else begin
          // column moves during an access ride on the pending count
          lat_en = col_chg;
          if (tmr_done) state_d = ST_RDY;
        end
      end
      ST_RDY: begin
        if (ce_s) begin
          state_d = ST_PRE;
          tmr_ld  = 1'b1;
          tmr_val = LD_PRE;
        end else if (row_chg) begin
          state_d = ST_ACC;
          tmr_ld  = 1'b1;
          tmr_val = LD_RAND;
          lat_en  = 1'b1;
        end else if (col_chg) begin
          state_d = ST_ACC;
          tmr_ld  = 1'b1;
          tmr_val = LD_PAGE;
          lat_en  = 1'b1;
        end
      end
      ST_PRE: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      we_q    <= we_s;
      if (lat_en) addr_q <= addr_s;
    end
  end

  // write ends on the first of chip-enable rise (write enable low) or write-enable rise
  assign wr_end = (state_q == ST_RDY) && ((ce_s && !we_s) || we_rise);
  assign mem_we = wr_end && lvl_s && !wp_protected_i;

  pgmem_array #(.AW(STORE_AW), .DW(DW)) u_array (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i(addr_q[STORE_AW-1:0]),
    .wdata_i(dq_s),
    .raddr_i(addr_q[STORE_AW-1:0]),
    .rdata_o(rd_data)
  );

  assign wp_addr_o = addr_q;
  assign dq_o      = rd_data;
  assign dq_oe_o   = (state_q == ST_RDY) && !oe_s && we_s && lvl_s;

  // R3
  page_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RDY && !ce_s && !row_chg && col_chg) |=>
      (state_q == ST_ACC && tmr_cnt == LD_PAGE));

  // R4
  rand_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RDY && !ce_s && row_chg) |=> (tmr_cnt == LD_RAND));

  // R5
  pre_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRE) |=> (state_q == ST_PRE || state_q == ST_IDLE));

  // R6
  drive_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> ($past(state_q) == ST_ACC || $past(oe_s) ||
                        !$past(we_s) || !$past(lvl_s)));

  // R8
  ce_end_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we && ce_s) |=> (state_q == ST_PRE));
endmodule

// File: tb/pgmem_ctrl_tb.sv
module pgmem_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TCE  = 6;
  localparam int TRND = 35;
  localparam int TPG  = 3;
  localparam int TPRE = 29;
  localparam int SAW  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lvl_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        doe;
  logic [16:0] wpaddr;
  logic [7:0]  prot_mask = '0;
  logic        wp_prot;

  int tests = 0;
  int fails = 0;

  typedef struct {
    bit          oe;
    logic [7:0]  d;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  logic [7:0] ref_mem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign wp_prot = prot_mask[wpaddr[16:14]];

  pgmem_ctrl #(
    .STORE_AW(SAW), .T_CE(TCE), .T_RAND(TRND), .T_PAGE(TPG), .T_PRE(TPRE)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .lockout_ni(lvl_n), .addr_i(addr), .dq_i(din), .dq_o(dout),
    .dq_oe_o(doe), .wp_addr_o(wpaddr), .wp_protected_i(wp_prot)
  );

  function automatic int rk(logic [16:0] a);
    return int'(a & ((17'd1 << SAW) - 17'd1));
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // push an expected bus state, compared by the monitor at the next falling edge
  task automatic expect_bus(bit oe, logic [7:0] d, string req);
    exp_t it;
    #1;
    it.oe = oe; it.d = d; it.req = req;
    exp_q.push_back(it);
  endtask

  always begin
    @(negedge clk);
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      tests++;
      if (doe !== e.oe || (e.oe && dout !== e.d)) begin
        fails++;
        $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h",
                 e.req, doe, dout, e.oe, e.d);
      end
    end
  end

  task automatic check_addr(logic [16:0] got, logic [16:0] exp, string req);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %05h expected %05h", req, got, exp);
    end
  endtask

  task automatic release_ce();
    ce_n = 1'b1;
    cyc(TPRE + 4);
  endtask

  task automatic write_we(logic [16:0] a, logic [7:0] d);
    addr = a; din = d; we_n = 1'b1; ce_n = 1'b0;
    cyc(TCE + 4);
    we_n = 1'b0;
    cyc(3);
    we_n = 1'b1;
    cyc(3);
    release_ce();
    if (lvl_n && !prot_mask[a[16:14]]) ref_mem[rk(a)] = d;
  endtask

  task automatic read_chk(logic [16:0] a, string req);
    addr = a; we_n = 1'b1; ce_n = 1'b0;
    cyc(TCE + 3);
    expect_bus(1'b1, ref_mem[rk(a)], req);
    cyc(1);
    release_ce();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    oe_n = 1'b0;
    cyc(5);
    rst_n = 1'b1;
    cyc(4);
    expect_bus(1'b0, 8'h00, "R1 reset idle");
    cyc(2);

    write_we(17'h00123, 8'hA5);
    write_we(17'h04ABC, 8'h3C);
    write_we(17'h00300, 8'h44);

    // R2 access timing
    addr = 17'h00123; ce_n = 1'b0;
    cyc(TCE);
    expect_bus(1'b0, 8'h00, "R2 before access time");
    cyc(3);
    expect_bus(1'b1, 8'hA5, "R2 chip-enable read");
    // R6 output enable gating
    oe_n = 1'b1;
    cyc(2);
    expect_bus(1'b0, 8'h00, "R6 oe high tri-state");
    oe_n = 1'b0;
    cyc(2);
    expect_bus(1'b1, 8'hA5, "R6 oe low again");
    cyc(1);
    release_ce();
    read_chk(17'h04ABC, "R2 second address");

    // R8 page write, three bytes of one row
    addr = 17'h00A10; ce_n = 1'b0;
    cyc(TCE + 4);
    for (int i = 0; i < 3; i++) begin
      addr = 17'h00A10 | 17'(i);
      if (i > 0) cyc(TPG + 4);
      din = 8'h11 * 8'(i + 1);
      we_n = 1'b0;
      cyc(3);
      we_n = 1'b1;
      cyc(3);
      ref_mem[rk(17'h00A10 | 17'(i))] = 8'h11 * 8'(i + 1);
    end
    release_ce();

    // R3 page reads
    addr = 17'h00A10; ce_n = 1'b0;
    cyc(TCE + 3);
    expect_bus(1'b1, 8'h11, "R8 page byte 0");
    addr = 17'h00A11;
    cyc(2);
    expect_bus(1'b0, 8'h00, "R3 released on column change");
    cyc(TPG + 1);
    expect_bus(1'b1, 8'h22, "R3 page byte 1");
    addr = 17'h00A12;
    cyc(TPG + 3);
    expect_bus(1'b1, 8'h33, "R3 page byte 2");
    // R4 random access by row change
    addr = 17'h00123;
    cyc(TPG + 3);
    expect_bus(1'b0, 8'h00, "R4 no page timing on row change");
    cyc(TRND - TPG);
    expect_bus(1'b1, 8'hA5, "R4 random read");
    cyc(1);
    release_ce();

    // R5 precharge enforcement
    addr = 17'h00123; ce_n = 1'b0;
    cyc(TCE + 3);
    expect_bus(1'b1, 8'hA5, "R5 first access");
    cyc(1);
    ce_n = 1'b1;
    cyc(5);
    ce_n = 1'b0;
    cyc(TCE + 3);
    expect_bus(1'b0, 8'h00, "R5 held off by precharge");
    cyc(TPRE);
    expect_bus(1'b1, 8'hA5, "R5 access after precharge");
    cyc(1);
    release_ce();

    // R7 write-enable-controlled write
    addr = 17'h04ABC; din = 8'h5A; ce_n = 1'b0;
    cyc(TCE + 3);
    expect_bus(1'b1, 8'h3C, "R7 starts as read");
    we_n = 1'b0;
    cyc(2);
    expect_bus(1'b0, 8'h00, "R7 released by write enable");
    cyc(2);
    we_n = 1'b1;
    cyc(3);
    ref_mem[rk(17'h04ABC)] = 8'h5A;
    expect_bus(1'b1, 8'h5A, "R8 written on write-enable rise");
    cyc(1);
    release_ce();

    // R8 chip-enable-controlled write
    addr = 17'h00200; din = 8'h77; we_n = 1'b0;
    cyc(1);
    ce_n = 1'b0;
    cyc(TCE + 4);
    expect_bus(1'b0, 8'h00, "R7 no drive while write enable low");
    ce_n = 1'b1;
    cyc(1);
    we_n = 1'b1;
    cyc(TPRE + 4);
    ref_mem[rk(17'h00200)] = 8'h77;
    read_chk(17'h00200, "R8 chip-enable write");

    // R9 write ended before access time
    addr = 17'h00300; din = 8'h99; we_n = 1'b0;
    cyc(1);
    ce_n = 1'b0;
    cyc(2);
    ce_n = 1'b1;
    cyc(1);
    we_n = 1'b1;
    cyc(TPRE + 4);
    read_chk(17'h00300, "R9 early write dropped");

    // R10 lockout
    lvl_n = 1'b0;
    cyc(3);
    addr = 17'h00123; ce_n = 1'b0;
    cyc(TCE + 3);
    expect_bus(1'b0, 8'h00, "R10 no drive under lockout");
    cyc(1);
    release_ce();
    write_we(17'h00123, 8'hEE);
    lvl_n = 1'b1;
    cyc(3);
    read_chk(17'h00123, "R10 write blocked");

    // R11 sector protection (sector 1 = 04000h..07FFFh)
    prot_mask = 8'b0000_0010;
    write_we(17'h04ABC, 8'h81);
    addr = 17'h04ABC; ce_n = 1'b0;
    cyc(TCE + 3);
    expect_bus(1'b1, ref_mem[rk(17'h04ABC)], "R11 protected write dropped");
    check_addr(wpaddr, 17'h04ABC, "R11 query address");
    cyc(1);
    release_ce();
    write_we(17'h00123, 8'h3E);
    read_chk(17'h00123, "R11 unprotected write lands");
    prot_mask = '0;

    // R12 aliasing of upper address bits
    write_we(17'h1F123, 8'h6D);
    read_chk(17'h00123, "R12 alias shares byte");

    cyc(4);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule